// File: doc/BRIEF.md
# Parallel Flash Read Path

This block is the read side of a 16-bit parallel NOR-style flash device. A host drives an address with an address-valid strobe. The block fetches a four-word page from an internal array port into a page buffer, then places the selected word on the data bus. Everything is sampled on one internal clock.

The block has two read modes, chosen by a mode bit in a small configuration register. In the asynchronous page mode, the address flows through while the strobe is low and is held once the strobe goes high. The two lowest address bits pick a word from the buffered page. In the clocked burst mode, a burst begins on a strobe edge. A WAIT flag stays high for a programmable number of cycles, and after that one word appears per cycle, wrapping inside the aligned group of four.

A separate read-state register picks the data source: array, identifier, status or query. Command decoding happens outside this block. That logic writes the configuration and the read state through two plain write strobes.

Top module: `flash_rd_path`

## Requirements
- R1: `dq_oe` is high exactly when `ce_n` and `oe_n` are both low.
- R2: After reset the block is in asynchronous page mode with read state array (code 0), `wait_o` is low and no array fetch is pending.
- R3: In asynchronous mode, while the requested page is not yet buffered, `dq_out` is zero. The block fetches the page `addr >> 2` once through `arr_rd_en`/`arr_page`/`arr_space`, with `arr_rdata` word i in bits [16i+15:16i]. After that, `dq_out` shows word `addr[1:0]` of that page.
- R4: In asynchronous mode, changing only `addr[1:0]` inside a buffered page changes `dq_out` in the same cycle and raises no new `arr_rd_en`.
- R5: In asynchronous mode, the address passes through while `adv_n` is low. While `adv_n` is high, the block uses the last address sampled with `adv_n` low.
- R6: In asynchronous mode, `wait_o` stays low.
- R7: Burst mode is selected when configuration bit 15 is 0, and the latency field is bits [13:11] with value L. A burst starts on a clock edge where `ce_n` and `adv_n` are low and, at the previous edge, one of them was high. `wait_o` is then high for L cycles, and the first word is driven after the L-th edge following the start edge.
- R8: Latency codes 0 and 1 behave as 2.
- R9: After the first word of a burst, each clock edge advances to the next word of the same aligned four-word group, wrapping from offset 3 to offset 0.
- R10: Read-state codes are 0 array, 1 identifier, 2 status, 3 query. Codes 0, 1 and 3 are fetched with `arr_space` equal to the code. Status returns `status_word` directly. The state changes only on `rs_we`.
- R11: A buffered page from another read state is never shown. A read-state write that lands in the same cycle as a page capture leads to a fresh fetch in the new state.
- R12: A burst ends, with `wait_o` low, one edge after `ce_n` is sampled high or after the configuration switches to asynchronous mode.
- R13: A new burst start during a running burst restarts the latency count at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and burst clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr | input | ADDR_W | Word address |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Data bus drive enable |
| wait_o | output | 1 | Burst data not yet valid |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration value (bit 15 mode, bits 13:11 latency) |
| rs_we | input | 1 | Read-state write strobe |
| rs_wdata | input | 2 | New read-state code |
| status_word | input | 16 | Value returned in the status read state |
| arr_rd_en | output | 1 | Array page fetch request |
| arr_page | output | ADDR_W-2 | Page address of the fetch |
| arr_space | output | 2 | Read-state code of the fetch |
| arr_rdata | input | 64 | Four words returned one cycle after the request |

## Verification
The two functions that can fall in the same cycle are the capture of a fetched page and a read-state write. The bench starts an asynchronous array fetch and times `rs_we` so that it is sampled on the very edge at which the page data is written into the buffer. It then checks that the output shows the identifier word for that address, not the array word. It also checks that exactly two fetches were issued. A second collision, a new strobe edge during a burst's latency window, is judged by counting WAIT cycles from the second start.

// File: rtl/frp_pkg.sv
package frp_pkg;

    localparam int WORD_W     = 16;
    localparam int OFS_W      = 2;
    localparam int PAGE_WORDS = 1 << OFS_W;
    localparam int CFG_W      = 16;
    localparam int LAT_W      = 3;
    localparam int MODE_BIT   = 15;
    localparam int LAT_LSB    = 11;
    localparam int LAT_MIN    = 2;
    localparam logic [LAT_W-1:0] LAT_RESET = 3'd7;
    localparam logic [CFG_W-1:0] CFG_USED =
        (CFG_W'(1) << MODE_BIT) | (CFG_W'((1 << LAT_W) - 1) << LAT_LSB);

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [PAGE_WORDS-1:0] page_t;

    typedef enum logic [1:0] {
        RS_ARRAY  = 2'd0,
        RS_IDENT  = 2'd1,
        RS_STATUS = 2'd2,
        RS_QUERY  = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic             async_mode;
        logic [LAT_W-1:0] lat;
    } rd_cfg_t;

    // Latency codes below the minimum act as the minimum.
    function automatic logic [LAT_W-1:0] lat_clamp(input logic [LAT_W-1:0] code);
        return (code < LAT_W'(LAT_MIN)) ? LAT_W'(LAT_MIN) : code;
    endfunction

endpackage

// File: rtl/frp_cfg_regs.sv
module frp_cfg_regs import frp_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             rs_we,
    input  logic [1:0]       rs_wdata,
    output rd_cfg_t          cfg,
    output rd_state_e        rs
);
    logic             async_q;
    logic [LAT_W-1:0] lat_q;
    rd_state_e        rs_q;
    logic             cfg_unused;

    always_ff @(posedge clk) begin
        if (rst) begin
            async_q <= 1'b1;
            lat_q   <= LAT_RESET;
            rs_q    <= RS_ARRAY;
        end else begin
            if (cfg_we) begin
                async_q <= cfg_wdata[MODE_BIT];
                lat_q   <= cfg_wdata[LAT_LSB +: LAT_W];
            end
            if (rs_we) begin
                rs_q <= rd_state_e'(rs_wdata);
            end
        end
    end

    assign cfg.async_mode = async_q;
    assign cfg.lat        = lat_clamp(lat_q);
    assign rs             = rs_q;
    assign cfg_unused     = ^(cfg_wdata & ~CFG_USED);

endmodule

// File: rtl/frp_addr_path.sv
module frp_addr_path import frp_pkg::*; #(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              async_mode,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              burst_start
);
    logic [ADDR_W-1:0] hold_addr;
    logic              adv_q;
    logic              ce_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_addr <= '0;
            adv_q     <= 1'b1;
            ce_q      <= 1'b1;
        end else begin
            adv_q <= adv_n;
            ce_q  <= ce_n;
            if (!adv_n) begin
                hold_addr <= addr;
            end
        end
    end

    // Transparent while the strobe is low, held once it goes high.
    assign eff_addr = adv_n ? hold_addr : addr;

    // A burst begins only on the first edge of a new strobe or enable.
    assign burst_start = !async_mode && !ce_n && !adv_n && (adv_q || ce_q);

endmodule

// File: rtl/frp_page_buf.sv
module frp_page_buf import frp_pkg::*; #(
    parameter int ADDR_W = 23
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req,
    input  logic [ADDR_W-OFS_W-1:0] req_page,
    input  rd_state_e               req_space,
    output logic                    arr_rd_en,
    output logic [ADDR_W-OFS_W-1:0] arr_page,
    output rd_state_e               arr_space,
    input  page_t                   arr_words,
    output page_t                   buf_words,
    output logic [ADDR_W-OFS_W-1:0] buf_page,
    output rd_state_e               buf_space,
    output logic                    buf_valid,
    output logic                    busy
);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic              cap_q;
    logic [PAGE_W-1:0] cap_page;
    rd_state_e         cap_space;

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_rd_en <= 1'b0;
            arr_page  <= '0;
            arr_space <= RS_ARRAY;
            cap_q     <= 1'b0;
            cap_page  <= '0;
            cap_space <= RS_ARRAY;
            buf_words <= '0;
            buf_page  <= '0;
            buf_space <= RS_ARRAY;
            buf_valid <= 1'b0;
        end else begin
            arr_rd_en <= req;
            if (req) begin
                arr_page  <= req_page;
                arr_space <= req_space;
            end
            // The array answers one cycle after the request.
            cap_q     <= arr_rd_en;
            cap_page  <= arr_page;
            cap_space <= arr_space;
            if (cap_q) begin
                buf_words <= arr_words;
                buf_page  <= cap_page;
                buf_space <= cap_space;
                buf_valid <= 1'b1;
            end
        end
    end

    assign busy = arr_rd_en | cap_q;

endmodule

// File: rtl/frp_burst_seq.sv
module frp_burst_seq import frp_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [LAT_W-1:0] lat,
    input  logic [OFS_W-1:0] start_ofs,
    output logic             active,
    output logic             dvalid,
    output logic [OFS_W-1:0] ofs
);
    logic [LAT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active <= 1'b0;
            dvalid <= 1'b0;
            cnt    <= '0;
            ofs    <= '0;
        end else if (start) begin
            active <= 1'b1;
            dvalid <= 1'b0;
            cnt    <= lat - LAT_W'(1);
            ofs    <= start_ofs;
        end else if (active && !dvalid) begin
            if (cnt == '0) begin
                dvalid <= 1'b1;
            end else begin
                cnt <= cnt - LAT_W'(1);
            end
        end else if (dvalid) begin
            // Linear order, wrapping inside the aligned group.
            ofs <= ofs + OFS_W'(1);
        end
    end

endmodule

// File: rtl/flash_rd_path.sv
module flash_rd_path import frp_pkg::*; #(
    parameter int ADDR_W = 23
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ce_n,
    input  logic                         oe_n,
    input  logic                         adv_n,
    input  logic [ADDR_W-1:0]            addr,
    output logic [WORD_W-1:0]            dq_out,
    output logic                         dq_oe,
    output logic                         wait_o,
    input  logic                         cfg_we,
    input  logic [CFG_W-1:0]             cfg_wdata,
    input  logic                         rs_we,
    input  logic [1:0]                   rs_wdata,
    input  logic [WORD_W-1:0]            status_word,
    output logic                         arr_rd_en,
    output logic [ADDR_W-OFS_W-1:0]      arr_page,
    output logic [1:0]                   arr_space,
    input  logic [PAGE_WORDS*WORD_W-1:0] arr_rdata
);
    localparam int PAGE_W = ADDR_W - OFS_W;

    rd_cfg_t           cfg;
    rd_state_e         rs;
    logic              async_mode;
    logic [ADDR_W-1:0] eff_addr;
    logic              burst_start;
    page_t             arr_words;
    page_t             buf_words;
    logic [PAGE_W-1:0] buf_page;
    rd_state_e         buf_space;
    rd_state_e         fetch_space;
    logic              buf_valid;
    logic              busy;
    logic              async_hit;
    logic              async_req;
    logic              fetch_req;
    logic              bst_active;
    logic              bst_valid;
    logic [OFS_W-1:0]  bst_ofs;
    word_t             async_word;
    word_t             burst_word;

    frp_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .rs_we     (rs_we),
        .rs_wdata  (rs_wdata),
        .cfg       (cfg),
        .rs        (rs)
    );

    assign async_mode = cfg.async_mode;

    frp_addr_path #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .ce_n        (ce_n),
        .adv_n       (adv_n),
        .addr        (addr),
        .async_mode  (async_mode),
        .eff_addr    (eff_addr),
        .burst_start (burst_start)
    );

    for (genvar gi = 0; gi < PAGE_WORDS; gi++) begin : g_unpack
        assign arr_words[gi] = arr_rdata[gi*WORD_W +: WORD_W];
    end

    // Async fetch on a miss; a burst start always fetches its page.
    assign async_hit = buf_valid && (buf_page == eff_addr[ADDR_W-1:OFS_W]) && (buf_space == rs);
    assign async_req = async_mode && !ce_n && (rs != RS_STATUS) && !async_hit && !busy;
    assign fetch_req = async_req || burst_start;

    frp_page_buf #(.ADDR_W(ADDR_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .req       (fetch_req),
        .req_page  (eff_addr[ADDR_W-1:OFS_W]),
        .req_space (rs),
        .arr_rd_en (arr_rd_en),
        .arr_page  (arr_page),
        .arr_space (fetch_space),
        .arr_words (arr_words),
        .buf_words (buf_words),
        .buf_page  (buf_page),
        .buf_space (buf_space),
        .buf_valid (buf_valid),
        .busy      (busy)
    );

    assign arr_space = fetch_space;

    frp_burst_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (burst_start),
        .abort     (async_mode || ce_n),
        .lat       (cfg.lat),
        .start_ofs (eff_addr[OFS_W-1:0]),
        .active    (bst_active),
        .dvalid    (bst_valid),
        .ofs       (bst_ofs)
    );

    always_comb begin
        if (rs == RS_STATUS) begin
            async_word = status_word;
        end else if (async_hit) begin
            async_word = buf_words[eff_addr[OFS_W-1:0]];
        end else begin
            async_word = '0;
        end
    end

    always_comb begin
        if (!bst_valid) begin
            burst_word = '0;
        end else if (rs == RS_STATUS) begin
            burst_word = status_word;
        end else begin
            burst_word = buf_words[bst_ofs];
        end
    end

    assign dq_out = async_mode ? async_word : burst_word;
    assign wait_o = !async_mode && bst_active && !bst_valid;
    assign dq_oe  = !ce_n && !oe_n;

endmodule

// File: rtl/frp_chk.sv
module frp_chk (
    input logic       clk,
    input logic       rst,
    input logic       ce_n,
    input logic       oe_n,
    input logic       dq_oe,
    input logic       wait_o,
    input logic       async_mode,
    input logic       cfg_we,
    input logic       arr_rd_en,
    input logic       burst_start,
    input logic       bst_valid,
    input logic [1:0] bst_ofs,
    input logic       rs_we,
    input logic [1:0] rs_code
);
    // R1
    bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> !dq_oe);

    // R6
    async_nowait_chk: assert property (@(posedge clk) disable iff (rst)
        async_mode |-> !wait_o);

    // R4
    fetch_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (async_mode && arr_rd_en) |=> !arr_rd_en);

    // R7
    start_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_start && !cfg_we) |=> wait_o);

    // R9
    burst_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (bst_valid && !burst_start && !ce_n && !async_mode) |=> (bst_ofs == 2'($past(bst_ofs) + 2'd1)));

    // R12
    ce_abort_chk: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !wait_o);

    // R10
    rs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rs_we |=> $stable(rs_code));

endmodule

bind flash_rd_path frp_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .dq_oe       (dq_oe),
    .wait_o      (wait_o),
    .async_mode  (async_mode),
    .cfg_we      (cfg_we),
    .arr_rd_en   (arr_rd_en),
    .burst_start (burst_start),
    .bst_valid   (bst_valid),
    .bst_ofs     (bst_ofs),
    .rs_we       (rs_we),
    .rs_code     (rs)
);

// File: tb/flash_rd_path_test.sv
module flash_rd_path_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 23;
    localparam int PW = AW - 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          ce_n, oe_n, adv_n;
    logic [AW-1:0] addr;
    logic [15:0]   dq_out;
    logic          dq_oe, wait_o;
    logic          cfg_we;
    logic [15:0]   cfg_wdata;
    logic          rs_we;
    logic [1:0]    rs_wdata;
    logic [15:0]   status_word;
    logic          arr_rd_en;
    logic [PW-1:0] arr_page;
    logic [1:0]    arr_space;
    logic [63:0]   arr_rdata = '0;

    int total = 0;
    int bad = 0;
    int fetch_cnt = 0;
    logic [PW-1:0] last_page = '0;
    logic [1:0] cur_rs = 2'd0;

    typedef struct { logic [15:0] w; string tag; } exp_t;
    exp_t expq[$];
    bit burst_watch = 0;
    bit async_take = 0;

    flash_rd_path #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n), .addr(addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .wait_o(wait_o),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rs_we(rs_we), .rs_wdata(rs_wdata),
        .status_word(status_word), .arr_rd_en(arr_rd_en), .arr_page(arr_page),
        .arr_space(arr_space), .arr_rdata(arr_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [1:0] sp, input logic [PW-1:0] pg, input int w);
        int v;
        v = (int'(sp) * 15361) ^ (int'(pg[15:0]) * 263) ^ (w * 4369) ^ 23130;
        return v[15:0];
    endfunction

    // Synchronous array model: data one cycle after the request.
    always @(posedge clk) begin
        if (arr_rd_en) begin
            for (int w = 0; w < 4; w++) arr_rdata[w*16 +: 16] <= mem_word(arr_space, arr_page, w);
            fetch_cnt <= fetch_cnt + 1;
            last_page <= arr_page;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w, input string tag);
        expq.push_back('{w, tag});
    endtask

    // Monitor: pops an expected word whenever the design presents one.
    always @(negedge clk) begin
        if (async_take || (burst_watch && !wait_o)) begin
            async_take = 0;
            if (expq.size() == 0) begin
                check(0, "scoreboard underflow", 32'(dq_out), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(dq_out == e.w, e.tag, 32'(dq_out), 32'(e.w));
            end
        end
    end

    task automatic sample_now();
        @(posedge clk); #1 async_take = 1;
        @(negedge clk); #1;
    endtask

    task automatic set_cfg(input bit am, input logic [2:0] code);
        @(posedge clk); #1 cfg_we = 1; cfg_wdata = {am, 1'b0, code, 11'h0};
        @(posedge clk); #1 cfg_we = 0;
    endtask

    task automatic set_rs(input logic [1:0] code);
        @(posedge clk); #1 rs_we = 1; rs_wdata = code;
        @(posedge clk); #1 rs_we = 0;
        cur_rs = code;
    endtask

    task automatic async_read(input logic [AW-1:0] a, input string tag);
        @(posedge clk); #1 addr = a; adv_n = 0;
        repeat (6) @(posedge clk);
        push((cur_rs == 2'd2) ? status_word : mem_word(cur_rs, a[AW-1:2], int'(a[1:0])), tag);
        sample_now();
    endtask

    task automatic burst_read(input logic [AW-1:0] a, input logic [2:0] code, input int n, input string tag);
        int lat;
        int wc;
        lat = (code < 3'd2) ? 2 : int'(code);
        for (int i = 0; i < n; i++)
            push(mem_word(cur_rs, a[AW-1:2], (int'(a[1:0]) + i) % 4), tag);
        @(posedge clk); #1 adv_n = 1;
        @(posedge clk); #1 addr = a; adv_n = 0;
        @(posedge clk); #1 adv_n = 1; burst_watch = 1;
        wc = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (wait_o) wc++;
            else break;
        end
        check(wc == lat, {tag, " wait length"}, 32'(wc), 32'(lat));
        repeat (n - 1) @(negedge clk);
        #1 burst_watch = 0;
        check(expq.size() == 0, {tag, " all words"}, 32'(expq.size()), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int f0;
        rst = 1; ce_n = 1; oe_n = 1; adv_n = 1; addr = '0;
        cfg_we = 0; cfg_wdata = '0; rs_we = 0; rs_wdata = '0; status_word = 16'hC3A5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 reset state, R1 bus off with chip disabled
        check(wait_o == 0, "R2 wait at reset", 32'(wait_o), 32'd0);
        check(arr_rd_en == 0, "R2 no fetch at reset", 32'(arr_rd_en), 32'd0);
        check(dq_oe == 0, "R1 bus off", 32'(dq_oe), 32'd0);
        @(posedge clk); #1 rst = 0; ce_n = 0;
        @(negedge clk);
        check(dq_oe == 0, "R1 oe_n high", 32'(dq_oe), 32'd0);
        @(posedge clk); #1 oe_n = 0;
        @(negedge clk);
        check(dq_oe == 1, "R1 both low", 32'(dq_oe), 32'd1);

        // R2 default async array read, R3 page fetch
        async_read(23'h001235, "R3 async array word");
        check(last_page == 21'(23'h001235 >> 2), "R3 fetched page", 32'(last_page), 32'(23'h001235 >> 2));
        check(wait_o == 0, "R6 wait low in async", 32'(wait_o), 32'd0);

        // R4 low address bits select within the buffer, no new fetch
        f0 = fetch_cnt;
        for (int o = 0; o < 4; o++) begin
            @(posedge clk); #1 addr = {21'(23'h001235 >> 2), 2'(o)};
            push(mem_word(2'd0, 21'(23'h001235 >> 2), o), "R4 page word");
            sample_now();
        end
        check(fetch_cnt == f0, "R4 no refetch", 32'(fetch_cnt), 32'(f0));

        // R5 address held while strobe high
        @(posedge clk); #1 adv_n = 1;
        @(posedge clk); #1 addr = 23'h07F00A;
        repeat (5) @(posedge clk);
        push(mem_word(2'd0, 21'(23'h001235 >> 2), 3), "R5 held address");
        sample_now();
        check(fetch_cnt == f0, "R5 no fetch while held", 32'(fetch_cnt), 32'(f0));
        async_read(23'h07F00A, "R5 pass-through");

        // R10 read-state sources
        set_rs(2'd1);
        async_read(23'h07F00A, "R10 identifier");
        set_rs(2'd3);
        async_read(23'h07F009, "R10 query");
        set_rs(2'd2);
        async_read(23'h07F009, "R10 status");
        @(posedge clk); #1 status_word = 16'h1E0F;
        push(16'h1E0F, "R10 status follows input");
        sample_now();
        set_rs(2'd0);
        async_read(23'h07F009, "R10 back to array");

        // R11 read-state write on the same edge as page capture
        f0 = fetch_cnt;
        @(posedge clk); #1 addr = 23'h002222;
        @(posedge clk);
        @(posedge clk); #1 rs_we = 1; rs_wdata = 2'd1;
        @(posedge clk); #1 rs_we = 0; cur_rs = 2'd1;
        repeat (6) @(posedge clk);
        push(mem_word(2'd1, 21'(23'h002222 >> 2), 2), "R11 collision result");
        sample_now();
        check(fetch_cnt == f0 + 2, "R11 refetch count", 32'(fetch_cnt), 32'(f0 + 2));
        set_rs(2'd0);

        // R7 R9 bursts
        set_cfg(1'b0, 3'd3);
        burst_read(23'h003456, 3'd3, 6, "R7 R9 burst lat3 wrap");
        set_cfg(1'b0, 3'd7);
        burst_read(23'h003458, 3'd7, 4, "R7 burst lat7");
        set_cfg(1'b0, 3'd0);
        burst_read(23'h00345B, 3'd0, 5, "R8 code0 as 2");
        set_cfg(1'b0, 3'd1);
        burst_read(23'h003461, 3'd1, 3, "R8 code1 as 2");
        set_rs(2'd3);
        set_cfg(1'b0, 3'd5);
        burst_read(23'h004001, 3'd5, 4, "R10 burst query");
        set_rs(2'd0);

        // R13 restart mid-burst
        @(posedge clk); #1 adv_n = 1;
        @(posedge clk); #1 addr = 23'h005000; adv_n = 0;
        @(posedge clk); #1 adv_n = 1;
        @(posedge clk);
        burst_read(23'h005106, 3'd5, 4, "R13 restart");

        // R12 ce_n abort
        @(posedge clk); #1 addr = 23'h006000; adv_n = 0;
        @(posedge clk); #1 adv_n = 1;
        @(posedge clk); #1 ce_n = 1;
        @(negedge clk);
        check(wait_o == 1, "R12 wait before abort", 32'(wait_o), 32'd1);
        @(negedge clk);
        check(wait_o == 0, "R12 ce abort", 32'(wait_o), 32'd0);
        @(posedge clk); #1 ce_n = 0;

        // R12 mode abort
        set_cfg(1'b0, 3'd7);
        @(posedge clk); #1 addr = 23'h006100; adv_n = 0;
        @(posedge clk); #1 adv_n = 1;
        @(negedge clk);
        check(wait_o == 1, "R12 wait in burst", 32'(wait_o), 32'd1);
        set_cfg(1'b1, 3'd7);
        @(negedge clk);
        check(wait_o == 0, "R12 mode abort", 32'(wait_o), 32'd0);
        async_read(23'h006103, "R12 async after abort");

        check(expq.size() == 0, "scoreboard drained", 32'(expq.size()), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule